// File: doc/BRIEF.md
# Z80 Banked Memory Mapper

This block sits between a Z80 CPU and a RAM array of up to 1MB. It turns the 16-bit CPU address into a 20-bit physical address. Physical memory is treated as 64 banks of 16KB each. The upper half of CPU space is tied to two fixed banks. The lower half is cut into two 16KB windows, and each window is steered by its own 6-bit bank register.

Software programs the two bank registers with I/O writes to a pair of adjacent port numbers. It can read them back with I/O reads on the same ports. The translation is purely combinational. A register write is clocked in at the edge that ends the I/O write cycle, so the next memory access already uses the new bank. A RAM chip-enable output follows the memory request strobe.

Top module: `z80_bank_mapper`

## Requirements
- R1: For CPU addresses with bits 15:14 = 00, physical address bits 19:14 equal the window-0 bank register.
- R2: For CPU addresses with bits 15:14 = 01, physical address bits 19:14 equal the window-1 bank register.
- R3: CPU addresses with bits 15:14 = 10 map to physical bank 0x02, and those with bits 15:14 = 11 map to physical bank 0x03. The bank registers have no influence on these ranges.
- R4: Physical address bits 13:0 always equal CPU address bits 13:0.
- R5: While reset is active and after it is released, the window-0 register holds 0x00 and the window-1 register holds 0x01 until they are written.
- R6: An I/O write cycle (iorq_n=0, wr_n=0) at a rising clock edge stores data bits 5:0 into a register. The port is taken from cpu_addr[7:0]: port PORT_BASE selects window 0 and PORT_BASE+1 selects window 1. Data bits 7:6 are discarded.
- R7: Writes to any other port, and write cycles with iorq_n high, leave both registers unchanged.
- R8: While iorq_n=0 and rd_n=0 with the port at PORT_BASE or PORT_BASE+1, reg_rd_en is 1 and reg_rd_data is {2'b00, register}. Otherwise reg_rd_en is 0 and reg_rd_data is 0x00.
- R9: A register write changes the translation seen from the clock cycle after the write edge. The cycle that carries the write still uses the old bank.
- R10: ram_ce_n equals mreq_n in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples I/O writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus; bits 7:0 carry the port number in I/O cycles |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cpu_wdata | input | 8 | Data from the CPU |
| reg_rd_data | output | 8 | Bank register readback value |
| reg_rd_en | output | 1 | High while a register readback is being driven |
| phys_addr | output | 20 | Translated physical address |
| ram_ce_n | output | 1 | RAM chip enable, active low |

## Verification
An I/O write to a bank register and the translation of an address inside that same register's window can fall in the same cycle, because the address bus keeps an arbitrary high byte during the I/O cycle. The bench provokes this on purpose: it issues a write to window 0 while address bits 15:14 are 00, and it also does so through random stimulus. A behavioural model updates its copy of the bank only at the clock edge. On that basis the write cycle is judged to show the old bank and the following cycle the new one. Every output is compared with the model in every cycle.

// File: rtl/z80map_pkg.sv
package z80map_pkg;
  localparam int DEF_BANK_W  = 6;
  localparam int DEF_OFF_W   = 14;
  localparam int DEF_PORT_W  = 8;
  localparam int DEF_DATA_W  = 8;
  localparam int NUM_WIN     = 2;
  localparam int REGION_W    = 2;

  typedef enum logic [REGION_W-1:0] {
    RGN_WIN0  = 2'b00,
    RGN_WIN1  = 2'b01,
    RGN_FIXLO = 2'b10,
    RGN_FIXHI = 2'b11
  } region_e;

  function automatic region_e region_of(input logic [REGION_W-1:0] top_bits);
    return region_e'(top_bits);
  endfunction

  function automatic logic is_window(input region_e r);
    return (r == RGN_WIN0) || (r == RGN_WIN1);
  endfunction
endpackage

// File: rtl/mapper_io_decode.sv
module mapper_io_decode #(
  parameter int PORT_W    = 8,
  parameter int PORT_BASE = 8'h78,
  parameter int NUM_WIN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [PORT_W-1:0] port,
  output logic [NUM_WIN-1:0] wr_hit,
  output logic [NUM_WIN-1:0] rd_hit
);
  logic io_wr;
  logic io_rd;
  assign io_wr = !iorq_n && !wr_n;
  assign io_rd = !iorq_n && !rd_n;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_sel
    logic match;
    assign match     = (port == PORT_W'(PORT_BASE + i));
    assign wr_hit[i] = io_wr && match;
    assign rd_hit[i] = io_rd && match;
  end

  assert_onehot_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
  assert_onehot_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit));
endmodule

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs #(
  parameter int BANK_W  = 6,
  parameter int DATA_W  = 8,
  parameter int NUM_WIN = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_WIN-1:0]              wr_hit,
  input  logic [NUM_WIN-1:0]              rd_hit,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_WIN-1:0][BANK_W-1:0]  bank_q,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            rd_en
);
  localparam int PAD_W = DATA_W - BANK_W;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bank_q[i] <= BANK_W'(i);
      else if (wr_hit[i]) bank_q[i] <= wdata[BANK_W-1:0];
    end

    assert_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> (bank_q[i] == $past(wdata[BANK_W-1:0])));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[i] |=> $stable(bank_q[i]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (rd_hit[i]) rd_data = {{PAD_W{1'b0}}, bank_q[i]};
    end
  end
  assign rd_en = |rd_hit;

  assert_rd_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_data[DATA_W-1:BANK_W] == '0));
  assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import z80map_pkg::*;
#(
  parameter int BANK_W      = 6,
  parameter int OFF_W       = 14,
  parameter int NUM_WIN     = 2,
  parameter int FIX_BANK_LO = 2,
  parameter int FIX_BANK_HI = 3
) (
  input  logic [OFF_W+1:0]                cpu_addr,
  input  logic [NUM_WIN-1:0][BANK_W-1:0]  bank_q,
  output logic [BANK_W+OFF_W-1:0]         phys_addr,
  output region_e                         region
);
  logic [BANK_W-1:0] sel_bank;

  assign region = region_of(cpu_addr[OFF_W+1:OFF_W]);

  always_comb begin
    unique case (region)
      RGN_WIN0:  sel_bank = bank_q[0];
      RGN_WIN1:  sel_bank = bank_q[1];
      RGN_FIXLO: sel_bank = BANK_W'(FIX_BANK_LO);
      default:   sel_bank = BANK_W'(FIX_BANK_HI);
    endcase
  end

  assign phys_addr = {sel_bank, cpu_addr[OFF_W-1:0]};
endmodule

// File: rtl/z80_bank_mapper.sv
module z80_bank_mapper
  import z80map_pkg::*;
#(
  parameter int BANK_W      = DEF_BANK_W,
  parameter int OFF_W       = DEF_OFF_W,
  parameter int PORT_W      = DEF_PORT_W,
  parameter int DATA_W      = DEF_DATA_W,
  parameter int PORT_BASE   = 8'h78,
  parameter int FIX_BANK_LO = 2,
  parameter int FIX_BANK_HI = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OFF_W+1:0]          cpu_addr,
  input  logic                      mreq_n,
  input  logic                      iorq_n,
  input  logic                      rd_n,
  input  logic                      wr_n,
  input  logic [DATA_W-1:0]         cpu_wdata,
  output logic [DATA_W-1:0]         reg_rd_data,
  output logic                      reg_rd_en,
  output logic [BANK_W+OFF_W-1:0]   phys_addr,
  output logic                      ram_ce_n
);
  localparam int PHYS_W = BANK_W + OFF_W;

  logic [NUM_WIN-1:0]             wr_hit;
  logic [NUM_WIN-1:0]             rd_hit;
  logic [NUM_WIN-1:0][BANK_W-1:0] bank_q;
  region_e                        region;

  mapper_io_decode #(
    .PORT_W(PORT_W), .PORT_BASE(PORT_BASE), .NUM_WIN(NUM_WIN)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .port(cpu_addr[PORT_W-1:0]), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  mapper_bank_regs #(
    .BANK_W(BANK_W), .DATA_W(DATA_W), .NUM_WIN(NUM_WIN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(rd_hit),
    .wdata(cpu_wdata), .bank_q(bank_q), .rd_data(reg_rd_data),
    .rd_en(reg_rd_en)
  );

  mapper_xlate #(
    .BANK_W(BANK_W), .OFF_W(OFF_W), .NUM_WIN(NUM_WIN),
    .FIX_BANK_LO(FIX_BANK_LO), .FIX_BANK_HI(FIX_BANK_HI)
  ) u_xlate (
    .cpu_addr(cpu_addr), .bank_q(bank_q), .phys_addr(phys_addr),
    .region(region)
  );

  assign ram_ce_n = mreq_n;

  assert_win0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[OFF_W+1:OFF_W] == 2'b00) |-> (phys_addr[PHYS_W-1:OFF_W] == bank_q[0]));
  assert_win1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[OFF_W+1:OFF_W] == 2'b01) |-> (phys_addr[PHYS_W-1:OFF_W] == bank_q[1]));
  assert_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[OFF_W+1] |-> (phys_addr[PHYS_W-1:OFF_W] ==
      (cpu_addr[OFF_W] ? BANK_W'(FIX_BANK_HI) : BANK_W'(FIX_BANK_LO))));
  assert_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);
  assert_next_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[0] |=> ((cpu_addr[OFF_W+1:OFF_W] != 2'b00) ||
                   (phys_addr[PHYS_W-1:OFF_W] == $past(cpu_wdata[BANK_W-1:0]))));
  assert_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce_n == mreq_n);
endmodule

// File: tb/z80_bank_mapper_bench.sv
module z80_bank_mapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 8'h78;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  cpu_wdata = 8'h0;
  logic [7:0]  reg_rd_data;
  logic        reg_rd_en;
  logic [19:0] phys_addr;
  logic        ram_ce_n;

  int checks = 0;
  int errors = 0;
  int m_bank [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  z80_bank_mapper u_z80_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .cpu_wdata(cpu_wdata),
    .reg_rd_data(reg_rd_data), .reg_rd_en(reg_rd_en),
    .phys_addr(phys_addr), .ram_ce_n(ram_ce_n)
  );

  // Reference model: bank copies change only at a clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bank[0] <= 0;
      m_bank[1] <= 1;
    end else if (!iorq_n && !wr_n) begin
      if (cpu_addr[7:0] == 8'(BASE))     m_bank[0] <= cpu_wdata % 64;
      if (cpu_addr[7:0] == 8'(BASE + 1)) m_bank[1] <= cpu_wdata % 64;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int rgn, bank, exp_phys, exp_rd, exp_en, port;
    string tag;
    rgn  = cpu_addr / 16384;
    bank = (rgn < 2) ? m_bank[rgn] : rgn;
    exp_phys = bank * 16384 + (cpu_addr % 16384);
    tag = (rgn == 0) ? "R1 window0" : (rgn == 1) ? "R2 window1" : "R3 fixed";
    chk(tag, int'(phys_addr), exp_phys);
    chk("R4 offset", int'(phys_addr % 16384), cpu_addr % 16384);
    chk("R10 ce", int'(ram_ce_n), int'(mreq_n));
    port = cpu_addr % 256;
    exp_en = (!iorq_n && !rd_n && (port == BASE || port == BASE + 1)) ? 1 : 0;
    exp_rd = exp_en ? m_bank[port - BASE] : 0;
    chk("R8 rd_en", int'(reg_rd_en), exp_en);
    chk("R8 rd_data", int'(reg_rd_data), exp_rd);
  endtask

  // one bus cycle: check the previous cycle's outputs, then drive new inputs
  task automatic cyc(input logic [15:0] a, input logic mq, input logic io,
                     input logic rd, input logic wr, input logic [7:0] d);
    @(negedge clk);
    compare_all();
    cpu_addr = a; mreq_n = mq; iorq_n = io; rd_n = rd; wr_n = wr; cpu_wdata = d;
  endtask

  task automatic io_write(input int port, input logic [7:0] d);
    cyc(16'(port), 1'b1, 1'b0, 1'b1, 1'b0, d);
  endtask

  task automatic io_read_expect(input int port, input int exp, input string tag);
    cyc(16'(port), 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    #1;
    chk(tag, int'(reg_rd_data), exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R5: reset values, visible on the readback and on the translation
    #1;
    chk("R5 win0 phys during reset", int'(phys_addr / 16384), 0);
    rst_n = 1'b1;
    io_read_expect(BASE, 0, "R5 win0 reset value");
    io_read_expect(BASE + 1, 1, "R5 win1 reset value");
    cyc(16'h4123, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    #1;
    chk("R5 win1 phys after reset", int'(phys_addr), 16'h4123 % 16384 + 16384);

    // R6: store low six bits, drop upper two
    io_write(BASE, 8'hFF);
    io_read_expect(BASE, 8'h3F, "R6 upper bits dropped");
    io_write(BASE + 1, 8'hA5);
    io_read_expect(BASE + 1, 8'h25, "R6 win1 store");

    // R7: other port and non-I/O write change nothing
    io_write(BASE + 2, 8'h11);
    cyc(16'(BASE), 1'b0, 1'b1, 1'b1, 1'b0, 8'h22);
    io_read_expect(BASE, 8'h3F, "R7 win0 unchanged");
    io_read_expect(BASE + 1, 8'h25, "R7 win1 unchanged");

    // R3: fixed ranges unaffected by register contents
    cyc(16'h8001, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    #1; chk("R3 bank2", int'(phys_addr), 2 * 16384 + 1);
    cyc(16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    #1; chk("R3 bank3", int'(phys_addr), 3 * 16384 + 16'h3FFF);

    // R9: write to window 0 with the address inside window 0
    cyc(16'h1000 | 16'(BASE), 1'b1, 1'b0, 1'b1, 1'b0, 8'h07);
    #1; chk("R9 old bank in write cycle", int'(phys_addr / 16384), 8'h3F);
    cyc(16'h1000, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    #1; chk("R9 new bank next cycle", int'(phys_addr / 16384), 7);

    // random traffic compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      int kind;
      logic [15:0] a;
      kind = $urandom_range(0, 9);
      a = 16'($urandom);
      if (kind < 4) begin
        cyc(a, 1'b0, 1'b1, kind[0], ~kind[0], 8'($urandom));
      end else begin
        a[7:0] = 8'(BASE + $urandom_range(0, 2));
        if (kind < 7) cyc(a, 1'b1, 1'b0, 1'b1, 1'b0, 8'($urandom));
        else          cyc(a, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
      end
      if (n == 2500) begin
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
      end
    end
    cyc(16'h0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    @(negedge clk);
    compare_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule